// File: doc/BRIEF.md
# Dual-Port Block Memory

This block is a synthesizable memory with two ports, A and B, each with its own clock, synchronous reset, enable, write enable, address, write data and read data. A parameter picks between a simple arrangement, where port A only writes and port B only reads, and a true dual-port arrangement, where both ports read and write the same storage. The two clocks may be tied together or may be unrelated.

Three more parameters shape each port's read side. The first sets what a port returns when it writes the address it is accessing: the new word, the old word, or its last output unchanged. The second adds a pipeline register so that read data arrives two clocks after the address instead of one. The third sets the word that a port reset forces onto the read output. Reset touches only the output registers and never the stored words.

Top module: `dp_ram`

## Requirements
- R1: A port stores `wdata` at `addr` on the rising edge of its clock when its enable and write enable are both high. A word written by one port can be read by the other port.
- R2: With `OUT_REG`=0, read data for the address presented at a rising edge with enable high appears after that same edge.
- R3: With `OUT_REG`=1, read data for the address presented at a rising edge appears after the next rising edge, provided enable is high at both edges.
- R4: With `COLL_MODE`=0 (write-first), a port that writes shows the word being written as its read data.
- R5: With `COLL_MODE`=1 (read-first), a port that writes shows the word the address held before the write.
- R6: With `COLL_MODE`=2 (no-change), a port that writes keeps its read output as it was.
- R7: While a port's enable is low, that port writes nothing and its read output does not change.
- R8: A port reset high at a rising edge sets that port's read output to `RST_VAL` after the edge. Reset takes priority over enable.
- R9: Reset leaves the stored words unchanged.
- R10: With `TRUE_DP`=0, port A's read output stays at `RST_VAL`, and port B's write enable has no effect on memory or on B's read data.
- R11: The two ports work on unrelated clocks: words written on port A's clock are read back correctly on port B's clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous output reset |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable |
| addr_a | input | AW | Port A address |
| wdata_a | input | DW | Port A write data |
| rdata_a | output | DW | Port A read data |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous output reset |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable (true dual-port only) |
| addr_b | input | AW | Port B address |
| wdata_b | input | DW | Port B write data |
| rdata_b | output | DW | Port B read data |

## Verification
The bench runs six true dual-port variants side by side, one for each collision mode with and without the output register, and one simple dual-port variant on two unrelated clocks. It reads back on one port words written on the other, and checks each at the exact cycle. A one-cycle latency error would show the neighbouring address's word. A wrong collision policy would show the new word where the old one is expected, or the reverse. It also holds enable low while write enable is high with fresh data: a design that ignored enable would change its output or overwrite the stored word. Reset is pulsed in the middle of reads to show that the output takes the reset word while the stored words survive. A design that cleared the storage, or that reset only the first stage of the pipeline, would fail this check.

// File: rtl/dp_ram.sv
module dp_ram #(
  parameter int DW = 8,
  parameter int AW = 6,
  parameter bit TRUE_DP = 1'b1,
  parameter int COLL_MODE = 0,
  parameter bit OUT_REG = 1'b0,
  parameter logic [DW-1:0] RST_VAL = '0
) (
  input  logic          clk_a,
  input  logic          rst_a,
  input  logic          en_a,
  input  logic          we_a,
  input  logic [AW-1:0] addr_a,
  input  logic [DW-1:0] wdata_a,
  output logic [DW-1:0] rdata_a,
  input  logic          clk_b,
  input  logic          rst_b,
  input  logic          en_b,
  input  logic          we_b,
  input  logic [AW-1:0] addr_b,
  input  logic [DW-1:0] wdata_b,
  output logic [DW-1:0] rdata_b
);
  localparam int DEPTH = 1 << AW;

  // Each port owns one bank and one tag bit per word; equal tags mean A wrote last.
  logic [DW-1:0] bank_a [DEPTH];
  logic [DW-1:0] bank_b [DEPTH];
  logic [DEPTH-1:0] tag_a, tag_b;

  logic wr_a, wr_b;
  logic [DW-1:0] cur_a, cur_b;
  logic [DW-1:0] s1_a, s1_b, fin_a, fin_b;

  assign wr_a = en_a & we_a;
  assign wr_b = TRUE_DP & en_b & we_b;

  assign cur_a = (!TRUE_DP || tag_a[addr_a] == tag_b[addr_a]) ? bank_a[addr_a] : bank_b[addr_a];
  assign cur_b = (!TRUE_DP || tag_a[addr_b] == tag_b[addr_b]) ? bank_a[addr_b] : bank_b[addr_b];

  always_ff @(posedge clk_a) begin
    if (wr_a) begin
      bank_a[addr_a] <= wdata_a;
      tag_a[addr_a]  <= tag_b[addr_a];
    end
  end

  always_ff @(posedge clk_b) begin
    if (wr_b) begin
      bank_b[addr_b] <= wdata_b;
      tag_b[addr_b]  <= ~tag_a[addr_b];
    end
  end

  always_ff @(posedge clk_a) begin
    if (!OUT_REG && rst_a) s1_a <= RST_VAL;
    else if (en_a) begin
      if (wr_a) begin
        if (COLL_MODE == 0) s1_a <= wdata_a;
        else if (COLL_MODE == 1) s1_a <= cur_a;
      end else s1_a <= cur_a;
    end
  end

  always_ff @(posedge clk_b) begin
    if (!OUT_REG && rst_b) s1_b <= RST_VAL;
    else if (en_b) begin
      if (wr_b) begin
        if (COLL_MODE == 0) s1_b <= wdata_b;
        else if (COLL_MODE == 1) s1_b <= cur_b;
      end else s1_b <= cur_b;
    end
  end

  generate
    if (OUT_REG) begin : g_oreg
      logic [DW-1:0] o_a, o_b;
      always_ff @(posedge clk_a) begin
        if (rst_a) o_a <= RST_VAL;
        else if (en_a) o_a <= s1_a;
      end
      always_ff @(posedge clk_b) begin
        if (rst_b) o_b <= RST_VAL;
        else if (en_b) o_b <= s1_b;
      end
      assign fin_a = o_a;
      assign fin_b = o_b;
    end else begin : g_noreg
      assign fin_a = s1_a;
      assign fin_b = s1_b;
    end
  endgenerate

  assign rdata_a = TRUE_DP ? fin_a : RST_VAL;
  assign rdata_b = fin_b;
endmodule

// File: rtl/dp_ram_chk.sv
module dp_ram_chk #(
  parameter int DW = 8,
  parameter bit TRUE_DP = 1'b1,
  parameter int COLL_MODE = 0,
  parameter bit OUT_REG = 1'b0,
  parameter logic [DW-1:0] RST_VAL = '0
) (
  input logic          clk_a,
  input logic          rst_a,
  input logic          en_a,
  input logic          we_a,
  input logic [DW-1:0] wdata_a,
  input logic [DW-1:0] rdata_a,
  input logic          clk_b,
  input logic          rst_b,
  input logic          en_b,
  input logic          we_b,
  input logic [DW-1:0] wdata_b,
  input logic [DW-1:0] rdata_b
);
  assert_rst_out_a_R8: assert property (@(posedge clk_a) rst_a |=> rdata_a == RST_VAL);
  assert_rst_out_b_R8: assert property (@(posedge clk_b) rst_b |=> rdata_b == RST_VAL);

  assert_idle_hold_a_R7: assert property (@(posedge clk_a) disable iff (rst_a)
    !en_a |=> $stable(rdata_a));
  assert_idle_hold_b_R7: assert property (@(posedge clk_b) disable iff (rst_b)
    !en_b |=> $stable(rdata_b));

  assert_wfirst_a_R4: assert property (@(posedge clk_a) disable iff (rst_a)
    (TRUE_DP && COLL_MODE == 0 && !OUT_REG && en_a && we_a) |=> rdata_a == $past(wdata_a));
  assert_wfirst_b_R4: assert property (@(posedge clk_b) disable iff (rst_b)
    (TRUE_DP && COLL_MODE == 0 && !OUT_REG && en_b && we_b) |=> rdata_b == $past(wdata_b));

  assert_nochange_a_R6: assert property (@(posedge clk_a) disable iff (rst_a)
    (TRUE_DP && COLL_MODE == 2 && !OUT_REG && en_a && we_a) |=> $stable(rdata_a));
  assert_nochange_b_R6: assert property (@(posedge clk_b) disable iff (rst_b)
    (TRUE_DP && COLL_MODE == 2 && !OUT_REG && en_b && we_b) |=> $stable(rdata_b));

  assert_sdp_a_quiet_R10: assert property (@(posedge clk_a) disable iff (rst_a)
    !TRUE_DP |-> rdata_a == RST_VAL);
endmodule

bind dp_ram dp_ram_chk #(
  .DW(DW), .TRUE_DP(TRUE_DP), .COLL_MODE(COLL_MODE), .OUT_REG(OUT_REG), .RST_VAL(RST_VAL)
) u_chk (
  .clk_a(clk_a), .rst_a(rst_a), .en_a(en_a), .we_a(we_a), .wdata_a(wdata_a), .rdata_a(rdata_a),
  .clk_b(clk_b), .rst_b(rst_b), .en_b(en_b), .we_b(we_b), .wdata_b(wdata_b), .rdata_b(rdata_b)
);

// File: tb/dp_ram_tb.sv
module dp_ram_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CLKB_PERIOD = 14;
  localparam int NV = 6;
  localparam logic [7:0] RSTV = 8'hA5;

  logic clk = 1'b0, clkb = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always #(CLKB_PERIOD/2) clkb = ~clkb;

  logic rst = 1'b1, en_a = 1'b0, we_a = 1'b0, en_b = 1'b0, we_b = 1'b0;
  logic [5:0] addr_a = '0, addr_b = '0;
  logic [7:0] wd_a = '0, wd_b = '0;
  logic [7:0] rda [NV];
  logic [7:0] rdb [NV];

  for (genvar g = 0; g < NV; g++) begin : g_var
    dp_ram #(.DW(8), .AW(6), .TRUE_DP(1'b1), .COLL_MODE(g % 3), .OUT_REG(g / 3), .RST_VAL(RSTV)) u_dut (
      .clk_a(clk), .rst_a(rst), .en_a(en_a), .we_a(we_a), .addr_a(addr_a), .wdata_a(wd_a), .rdata_a(rda[g]),
      .clk_b(clk), .rst_b(rst), .en_b(en_b), .we_b(we_b), .addr_b(addr_b), .wdata_b(wd_b), .rdata_b(rdb[g]));
  end

  logic s_en_a = 1'b0, s_we_a = 1'b0, s_en_b = 1'b0, s_we_b = 1'b0;
  logic [5:0] s_addr_a = '0, s_addr_b = '0;
  logic [7:0] s_wd_a = '0, s_wd_b = '0, s_rda, s_rdb;

  dp_ram #(.DW(8), .AW(6), .TRUE_DP(1'b0), .COLL_MODE(1), .OUT_REG(1'b0), .RST_VAL(RSTV)) u_dut (
    .clk_a(clk), .rst_a(rst), .en_a(s_en_a), .we_a(s_we_a), .addr_a(s_addr_a), .wdata_a(s_wd_a), .rdata_a(s_rda),
    .clk_b(clkb), .rst_b(rst), .en_b(s_en_b), .we_b(s_we_b), .addr_b(s_addr_b), .wdata_b(s_wd_b), .rdata_b(s_rdb));

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [7:0] ref_m [64];
  logic [7:0] sref [8];

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic stepb();
    @(posedge clkb);
    @(negedge clkb);
  endtask

  task automatic t_reset_state();
    rst = 1'b1;
    repeat (3) step();
    for (int v = 0; v < NV; v++) begin
      chk("R8 reset state A", rda[v], RSTV);
      chk("R8 reset state B", rdb[v], RSTV);
    end
    chk("R8 reset state sdp", s_rdb, RSTV);
    rst = 1'b0;
  endtask

  task automatic t_fill();
    en_b = 1'b0;
    for (int i = 0; i < 16; i++) begin
      en_a = 1'b1; we_a = 1'b1; addr_a = 6'(i); wd_a = 8'(i * 7 + 3);
      ref_m[i] = wd_a;
      step();
    end
    addr_a = 6'd40; wd_a = 8'h4E; ref_m[40] = 8'h4E; step();
    en_a = 1'b0; we_a = 1'b0;
    for (int i = 16; i < 32; i++) begin
      en_b = 1'b1; we_b = 1'b1; addr_b = 6'(i); wd_b = 8'(i * 5 + 1);
      ref_m[i] = wd_b;
      step();
    end
    addr_b = 6'd41; wd_b = 8'hB1; ref_m[41] = 8'hB1; step();
    for (int i = 0; i < 8; i++) begin
      addr_b = 6'(48 + i); wd_b = 8'(8'h60 + i); ref_m[48 + i] = wd_b;
      step();
    end
    en_b = 1'b0; we_b = 1'b0;
  endtask

  // R1 R2 R3: cross-port streaming reads
  task automatic t_stream();
    logic [5:0] pa, pb;
    pa = '0; pb = '0;
    en_a = 1'b1; en_b = 1'b1; we_a = 1'b0; we_b = 1'b0;
    for (int k = 0; k < 32; k++) begin
      addr_a = 6'((k + 16) % 32);
      addr_b = 6'(k);
      step();
      for (int v = 0; v < NV; v++) begin
        if (v < 3) begin
          chk("R1 R2 stream A", rda[v], ref_m[addr_a]);
          chk("R1 R2 stream B", rdb[v], ref_m[addr_b]);
        end else if (k > 0) begin
          chk("R3 stream A", rda[v], ref_m[pa]);
          chk("R3 stream B", rdb[v], ref_m[pb]);
        end
      end
      pa = addr_a; pb = addr_b;
    end
    en_a = 1'b0; en_b = 1'b0;
  endtask

  // R4 R5 R6: own-port write collision on both ports
  task automatic t_collide();
    logic [7:0] oa, ob, na, nb;
    string tag;
    oa = ref_m[40]; ob = ref_m[41]; na = 8'h3C; nb = 8'hC3;
    en_a = 1'b1; en_b = 1'b1; we_a = 1'b0; we_b = 1'b0; addr_a = 6'd40; addr_b = 6'd41;
    step(); step();
    we_a = 1'b1; we_b = 1'b1; wd_a = na; wd_b = nb;
    step();
    for (int v = 0; v < 3; v++) begin
      tag = (v == 0) ? "R4 write-first" : (v == 1) ? "R5 read-first" : "R6 no-change";
      chk(tag, rda[v], (v == 0) ? na : oa);
      chk(tag, rdb[v], (v == 0) ? nb : ob);
    end
    we_a = 1'b0; we_b = 1'b0;
    step();
    for (int v = 3; v < NV; v++) begin
      tag = (v == 3) ? "R4 R3 write-first" : (v == 4) ? "R5 R3 read-first" : "R6 R3 no-change";
      chk(tag, rda[v], (v == 3) ? na : oa);
      chk(tag, rdb[v], (v == 3) ? nb : ob);
    end
    for (int v = 0; v < 3; v++) begin
      chk("R1 after collide A", rda[v], na);
      chk("R1 after collide B", rdb[v], nb);
    end
    ref_m[40] = na; ref_m[41] = nb;
    en_a = 1'b0; en_b = 1'b0;
  endtask

  task automatic t_enable();
    en_a = 1'b1; en_b = 1'b1; we_a = 1'b0; we_b = 1'b0; addr_a = 6'd2; addr_b = 6'd3;
    step(); step();
    en_a = 1'b0; en_b = 1'b0; we_a = 1'b1; we_b = 1'b1;
    addr_a = 6'd6; wd_a = 8'hEE; addr_b = 6'd5; wd_b = 8'hDD;
    step(); step();
    for (int v = 0; v < NV; v++) begin
      chk("R7 hold A", rda[v], ref_m[2]);
      chk("R7 hold B", rdb[v], ref_m[3]);
    end
    en_a = 1'b1; en_b = 1'b1; we_a = 1'b0; we_b = 1'b0;
    step(); step();
    for (int v = 0; v < NV; v++) begin
      chk("R7 no write A", rda[v], ref_m[6]);
      chk("R7 no write B", rdb[v], ref_m[5]);
    end
    en_a = 1'b0; en_b = 1'b0;
  endtask

  task automatic t_reset_mid();
    en_a = 1'b1; en_b = 1'b1; we_a = 1'b0; we_b = 1'b0; addr_a = 6'd7; addr_b = 6'd20;
    step();
    rst = 1'b1;
    step();
    for (int v = 0; v < NV; v++) begin
      chk("R8 reset mid A", rda[v], RSTV);
      chk("R8 reset mid B", rdb[v], RSTV);
    end
    rst = 1'b0;
    step(); step();
    for (int v = 0; v < NV; v++) begin
      chk("R9 kept A", rda[v], ref_m[7]);
      chk("R9 kept B", rdb[v], ref_m[20]);
    end
    en_a = 1'b0; en_b = 1'b0;
  endtask

  task automatic t_sdp();
    for (int i = 0; i < 8; i++) begin
      s_en_a = 1'b1; s_we_a = 1'b1; s_addr_a = 6'(i); s_wd_a = 8'(8'h90 + i);
      sref[i] = s_wd_a;
      step();
      chk("R10 sdp A output", s_rda, RSTV);
    end
    s_en_a = 1'b1; s_we_a = 1'b0; s_addr_a = 6'd3;
    step();
    chk("R10 sdp A no read", s_rda, RSTV);
    s_en_a = 1'b0;
    @(negedge clkb);
    for (int i = 0; i < 8; i++) begin
      s_en_b = 1'b1; s_we_b = 1'b1; s_wd_b = 8'hFF; s_addr_b = 6'(i);
      stepb();
      chk("R11 R10 sdp B read", s_rdb, sref[i]);
    end
    s_we_b = 1'b0;
    for (int i = 0; i < 8; i++) begin
      s_addr_b = 6'(i);
      stepb();
      chk("R10 sdp B write ignored", s_rdb, sref[i]);
    end
    s_en_b = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    t_reset_state();
    t_fill();
    t_stream();
    t_collide();
    t_enable();
    t_reset_mid();
    t_sdp();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule